// File: doc/BRIEF.md
# Exception State Register File

This block holds the exception-related machine state of a small RISC core: a status word, a cause word, a saved exception PC and a captured faulting address. Each one can be read by register number through a combinational read port. When the pipeline signals that an exception is being taken, the block does four things. It stores the cause code. It saves the faulting instruction address, which is the incremented PC minus 4. It pushes a three-deep stack of kernel/enable pairs. It presents the fixed handler vector to the PC multiplexer.

A return-from-exception pop restores the previous kernel/enable pair and steers the PC multiplexer to the saved PC. Hardware interrupt lines are latched into pending bits of the cause word. Software can raise two pending bits of its own. An interrupt request is raised whenever the current enable bit is set and a pending level is also unmasked. Software writes to the status, cause and saved-PC registers use the same register numbers as reads.

Top module: `exc_state_regs`

## Requirements
- R1: After reset, every register reads 0, irq_req is 0 and redir_valid is 0 while exc_take and eret are low.
- R2: rd_data returns the faulting address for register 8, status for 12, cause for 13 and the saved PC for 14. Every other number reads 0, and undefined bits read 0: status 31..16 and 7..6, cause 31..16, 7..6 and 1..0.
- R3: A software write to register 12 stores bits 15..8 (one interrupt mask bit per level, 1 = enabled) and bits 5..0 (kernel/enable pairs: old at 5..4, previous at 3..2, current at 1..0, enable being the low bit of each pair).
- R4: On a cycle with exc_take high, status bits 5..0 become the old bits 3..0 shifted up by two with bits 1..0 cleared. The mask bits are unchanged.
- R5: On exception entry, cause bits 5..2 take exc_code. The codes are 0 interrupt, 4 load/fetch address error, 5 store address error, 6 fetch bus error, 7 data bus error, 8 syscall, 9 breakpoint, 10 reserved instruction and 12 overflow.
- R6: On exception entry, the saved PC (register 14) becomes exc_pc_next minus 4. Outside entry, a software write to register 14 loads it.
- R7: The faulting-address register (8) loads exc_bad_addr on entry only when exc_code is 4 or 5. It holds its value otherwise and cannot be written by software.
- R8: redir_valid is exc_take OR eret. redir_pc is 0x80000080 while exc_take is high, otherwise the saved PC while eret is high, otherwise 0.
- R9: Cause bit 10+i follows hardware line i one clock later and stays set while the line is held, whatever the mask and enable. It reads 0 one clock after the line drops, and also one clock after an accepted software write to register 13.
- R10: A software write to register 13 loads the software pending bits 9..8. Those bits hold their value otherwise.
- R11: irq_req is status bit 0 AND the OR over bits 15..8 of (cause bit AND status bit).
- R12: On a cycle with eret high and exc_take low, status bits 5..0 become {old pair, old pair, previous pair}.
- R13: exc_take has priority over eret. Any software write in a cycle with exc_take or eret high is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| exc_take | input | 1 | Exception taken this cycle |
| exc_code | input | 4 | Cause code of the exception |
| exc_pc_next | input | 32 | Incremented PC of the faulting instruction |
| exc_bad_addr | input | 32 | Memory address of the faulting reference |
| eret | input | 1 | Return from exception this cycle |
| sw_we | input | 1 | Software register write strobe |
| sw_addr | input | 5 | Register number for the write |
| sw_wdata | input | 32 | Write data |
| hw_irq | input | 6 | Hardware interrupt lines |
| rd_addr | input | 5 | Register number for the read |
| rd_data | output | 32 | Read data |
| redir_valid | output | 1 | PC multiplexer select for the exception path |
| redir_pc | output | 32 | Redirect target |
| irq_req | output | 1 | Interrupt request |

## Verification
The assertions take for granted that exc_take and eret stay low while reset is active or being released. They also assume that exc_code carries one of the listed codes and that exc_pc_next is at least 4 when an exception is taken, so the saved-PC subtraction does not wrap. The stimulus holds every control input idle through reset and uses only listed codes. Its PC values are well above 4. It changes hardware lines only in cycles where the latching delay is already accounted for by the expected values.

// File: rtl/exc_state_pkg.sv
package exc_state_pkg;
  localparam int unsigned XLEN       = 32;
  localparam int unsigned REG_AW     = 5;
  localparam int unsigned CODE_W     = 4;
  localparam int unsigned CODE_LSB   = 2;
  localparam int unsigned LEVEL_LSB  = 8;
  localparam int unsigned STACK_PAIRS = 3;
  localparam int unsigned STACK_W    = 2 * STACK_PAIRS;

  localparam logic [REG_AW-1:0] RNUM_BADV  = 5'd8;
  localparam logic [REG_AW-1:0] RNUM_STAT  = 5'd12;
  localparam logic [REG_AW-1:0] RNUM_CAUSE = 5'd13;
  localparam logic [REG_AW-1:0] RNUM_EPC   = 5'd14;

  typedef enum logic [CODE_W-1:0] {
    EC_INT   = 4'd0,
    EC_ADEL  = 4'd4,
    EC_ADES  = 4'd5,
    EC_IBE   = 4'd6,
    EC_DBE   = 4'd7,
    EC_SYS   = 4'd8,
    EC_BRK   = 4'd9,
    EC_RSVD  = 4'd10,
    EC_OVF   = 4'd12
  } exc_code_e;

  function automatic logic is_addr_fault(input logic [CODE_W-1:0] code);
    return (code == EC_ADEL) || (code == EC_ADES);
  endfunction
endpackage

// File: rtl/exc_status_stack.sv
module exc_status_stack
  import exc_state_pkg::*;
#(
  parameter int unsigned LEVELS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic               ret,
  input  logic               wr_en,
  input  logic [LEVELS-1:0]  wr_mask,
  input  logic [STACK_W-1:0] wr_stack,
  output logic [LEVELS-1:0]  mask_q,
  output logic [STACK_W-1:0] stack_q
);
  logic [LEVELS-1:0]  mask_d;
  logic [STACK_W-1:0] stack_d;
  logic               stack_en;
  logic               mask_en;

  assign stack_en = take | ret | wr_en;
  assign mask_en  = wr_en;

  always_comb begin
    stack_d = stack_q;
    if (take) begin
      stack_d = {stack_q[STACK_W-3:0], 2'b00};
    end else if (ret) begin
      stack_d = {stack_q[STACK_W-1:STACK_W-2], stack_q[STACK_W-1:2]};
    end else if (wr_en) begin
      stack_d = wr_stack;
    end
  end

  always_comb begin
    mask_d = mask_q;
    if (wr_en) mask_d = wr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stack_q <= '0;
    end else if (stack_en) begin
      stack_q <= stack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/exc_cause_unit.sv
module exc_cause_unit
  import exc_state_pkg::*;
#(
  parameter int unsigned HW_LINES = 6,
  parameter int unsigned SW_LINES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         take,
  input  logic [CODE_W-1:0]            code,
  input  logic                         wr_en,
  input  logic [SW_LINES-1:0]          wr_soft,
  input  logic [HW_LINES-1:0]          hw_irq,
  output logic [CODE_W-1:0]            code_q,
  output logic [HW_LINES+SW_LINES-1:0] pend_q
);
  logic [CODE_W-1:0]   code_d;
  logic [SW_LINES-1:0] soft_q;
  logic [SW_LINES-1:0] soft_d;
  logic [HW_LINES-1:0] hw_q;

  always_comb begin
    code_d = code_q;
    if (take) code_d = code;
  end

  always_comb begin
    soft_d = soft_q;
    if (wr_en) soft_d = wr_soft;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (take) begin
      code_q <= code_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_q <= '0;
    end else if (wr_en) begin
      soft_q <= soft_d;
    end
  end

  for (genvar i = 0; i < HW_LINES; i++) begin : g_line
    logic line_d;
    logic line_q;
    assign line_d = hw_irq[i] & ~wr_en;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        line_q <= 1'b0;
      end else begin
        line_q <= line_d;
      end
    end
    assign hw_q[i] = line_q;
  end

  assign pend_q = {hw_q, soft_q};
endmodule

// File: rtl/exc_addr_capture.sv
module exc_addr_capture
  import exc_state_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [CODE_W-1:0] code,
  input  logic [XLEN-1:0]   pc_next,
  input  logic [XLEN-1:0]   bad_addr,
  input  logic              epc_we,
  input  logic [XLEN-1:0]   epc_wdata,
  output logic [XLEN-1:0]   epc_q,
  output logic [XLEN-1:0]   badv_q
);
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  logic [XLEN-1:0] epc_d;
  logic [XLEN-1:0] badv_d;
  logic            epc_en;
  logic            badv_en;

  assign epc_en  = take | epc_we;
  assign badv_en = take & is_addr_fault(code);

  always_comb begin
    epc_d = epc_q;
    if (take) begin
      epc_d = pc_next - INSN_BYTES;
    end else if (epc_we) begin
      epc_d = epc_wdata;
    end
  end

  always_comb begin
    badv_d = badv_q;
    if (badv_en) badv_d = bad_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q <= '0;
    end else if (epc_en) begin
      epc_q <= epc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      badv_q <= '0;
    end else if (badv_en) begin
      badv_q <= badv_d;
    end
  end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_state_pkg::*;
#(
  parameter int unsigned     HW_LINES = 6,
  parameter int unsigned     SW_LINES = 2,
  parameter logic [XLEN-1:0] VECTOR   = 32'h8000_0080
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                exc_take,
  input  logic [CODE_W-1:0]   exc_code,
  input  logic [XLEN-1:0]     exc_pc_next,
  input  logic [XLEN-1:0]     exc_bad_addr,
  input  logic                eret,
  input  logic                sw_we,
  input  logic [REG_AW-1:0]   sw_addr,
  input  logic [XLEN-1:0]     sw_wdata,
  input  logic [HW_LINES-1:0] hw_irq,
  input  logic [REG_AW-1:0]   rd_addr,
  output logic [XLEN-1:0]     rd_data,
  output logic                redir_valid,
  output logic [XLEN-1:0]     redir_pc,
  output logic                irq_req
);
  localparam int unsigned LEVELS = HW_LINES + SW_LINES;
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_sync_n;
  logic                   sw_ok;
  logic                   wr_stat;
  logic                   wr_cause;
  logic                   wr_epc;
  logic [LEVELS-1:0]      mask_q;
  logic [STACK_W-1:0]     stack_q;
  logic [CODE_W-1:0]      code_q;
  logic [LEVELS-1:0]      pend_q;
  logic [HW_LINES-1:0]    hw_pend;
  logic [XLEN-1:0]        epc_q;
  logic [XLEN-1:0]        badv_q;
  logic [XLEN-1:0]        status_word;
  logic [XLEN-1:0]        cause_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= '0;
    end else begin
      rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync[SYNC_STAGES-1];

  assign sw_ok    = sw_we & ~exc_take & ~eret;
  assign wr_stat  = sw_ok & (sw_addr == RNUM_STAT);
  assign wr_cause = sw_ok & (sw_addr == RNUM_CAUSE);
  assign wr_epc   = sw_ok & (sw_addr == RNUM_EPC);

  exc_status_stack #(.LEVELS(LEVELS)) u_stack (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .take     (exc_take),
    .ret      (eret),
    .wr_en    (wr_stat),
    .wr_mask  (sw_wdata[LEVEL_LSB +: LEVELS]),
    .wr_stack (sw_wdata[STACK_W-1:0]),
    .mask_q   (mask_q),
    .stack_q  (stack_q)
  );

  exc_cause_unit #(.HW_LINES(HW_LINES), .SW_LINES(SW_LINES)) u_cause (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .take    (exc_take),
    .code    (exc_code),
    .wr_en   (wr_cause),
    .wr_soft (sw_wdata[LEVEL_LSB +: SW_LINES]),
    .hw_irq  (hw_irq),
    .code_q  (code_q),
    .pend_q  (pend_q)
  );

  exc_addr_capture u_addr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .take      (exc_take),
    .code      (exc_code),
    .pc_next   (exc_pc_next),
    .bad_addr  (exc_bad_addr),
    .epc_we    (wr_epc),
    .epc_wdata (sw_wdata),
    .epc_q     (epc_q),
    .badv_q    (badv_q)
  );

  assign hw_pend = pend_q[LEVELS-1:SW_LINES];

  always_comb begin
    status_word = '0;
    status_word[LEVEL_LSB +: LEVELS] = mask_q;
    status_word[STACK_W-1:0]         = stack_q;
  end

  always_comb begin
    cause_word = '0;
    cause_word[LEVEL_LSB +: LEVELS]  = pend_q;
    cause_word[CODE_LSB +: CODE_W]   = code_q;
  end

  always_comb begin
    case (rd_addr)
      RNUM_BADV:  rd_data = badv_q;
      RNUM_STAT:  rd_data = status_word;
      RNUM_CAUSE: rd_data = cause_word;
      RNUM_EPC:   rd_data = epc_q;
      default:    rd_data = '0;
    endcase
  end

  always_comb begin
    redir_valid = exc_take | eret;
    if (exc_take) begin
      redir_pc = VECTOR;
    end else if (eret) begin
      redir_pc = epc_q;
    end else begin
      redir_pc = '0;
    end
  end

  assign irq_req = stack_q[0] & (|(pend_q & mask_q));
endmodule

// File: rtl/exc_state_chk.sv
module exc_state_chk
  import exc_state_pkg::*;
#(
  parameter int unsigned     HW_LINES = 6,
  parameter logic [XLEN-1:0] VECTOR   = 32'h8000_0080
) (
  input logic                clk,
  input logic                rst_sync_n,
  input logic                exc_take,
  input logic                eret,
  input logic [XLEN-1:0]     exc_pc_next,
  input logic [HW_LINES-1:0] hw_irq,
  input logic [HW_LINES-1:0] hw_pend,
  input logic [STACK_W-1:0]  stack_q,
  input logic [XLEN-1:0]     epc_q,
  input logic                irq_req,
  input logic                redir_valid,
  input logic [XLEN-1:0]     redir_pc
);
  // R4
  entry_push_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exc_take |=> stack_q == {$past(stack_q[STACK_W-3:0]), 2'b00});

  // R12
  return_pop_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eret && !exc_take) |=> stack_q == {$past(stack_q[STACK_W-1:STACK_W-2]), $past(stack_q[STACK_W-1:2])});

  // R6
  epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exc_take |=> epc_q == $past(exc_pc_next) - 32'd4);

  // R8
  vector_redirect_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exc_take |-> (redir_valid && redir_pc == VECTOR));

  // R9
  pending_drop_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hw_irq == '0) |=> (hw_pend == '0));

  // R11
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_req |-> stack_q[0]);
endmodule

bind exc_state_regs exc_state_chk #(.HW_LINES(HW_LINES), .VECTOR(VECTOR)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .exc_take    (exc_take),
  .eret        (eret),
  .exc_pc_next (exc_pc_next),
  .hw_irq      (hw_irq),
  .hw_pend     (hw_pend),
  .stack_q     (stack_q),
  .epc_q       (epc_q),
  .irq_req     (irq_req),
  .redir_valid (redir_valid),
  .redir_pc    (redir_pc)
);

// File: tb/exc_state_regs_tb.sv
module exc_state_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int K_RD = 0, K_IRQ = 1, K_PC = 2, K_VAL = 3;

  logic        clk;
  logic        rst_n;
  logic        exc_take;
  logic [3:0]  exc_code;
  logic [31:0] exc_pc_next;
  logic [31:0] exc_bad_addr;
  logic        eret;
  logic        sw_we;
  logic [4:0]  sw_addr;
  logic [31:0] sw_wdata;
  logic [5:0]  hw_irq;
  logic [4:0]  rd_addr;
  logic [31:0] rd_data;
  logic        redir_valid;
  logic [31:0] redir_pc;
  logic        irq_req;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int    n_chk;
  int    n_fail;
  bit    done;

  exc_state_regs u_dut (
    .clk(clk), .rst_n(rst_n), .exc_take(exc_take), .exc_code(exc_code),
    .exc_pc_next(exc_pc_next), .exc_bad_addr(exc_bad_addr), .eret(eret),
    .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .hw_irq(hw_irq),
    .rd_addr(rd_addr), .rd_data(rd_data), .redir_valid(redir_valid),
    .redir_pc(redir_pc), .irq_req(irq_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin : monitor
    item_t it;
    logic [31:0] act;
    while (sb_q.size() != 0) begin
      it = sb_q.pop_front();
      case (it.kind)
        K_RD:    act = rd_data;
        K_IRQ:   act = {31'd0, irq_req};
        K_PC:    act = redir_pc;
        default: act = {31'd0, redir_valid};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push_sig(input int kind, input logic [31:0] exp, input string tag);
    sb_q.push_back('{kind, exp, tag});
  endtask

  task automatic push_reg(input logic [4:0] a, input logic [31:0] exp, input string tag);
    rd_addr = a;
    push_sig(K_RD, exp, tag);
  endtask

  task automatic check_reg(input logic [4:0] a, input logic [31:0] exp, input string tag);
    push_reg(a, exp, tag);
    tick();
  endtask

  task automatic sw_write(input logic [4:0] a, input logic [31:0] d);
    sw_we = 1'b1; sw_addr = a; sw_wdata = d;
    tick();
    sw_we = 1'b0;
  endtask

  task automatic take_exc(input logic [3:0] code, input logic [31:0] pcn, input logic [31:0] bad);
    exc_take = 1'b1; exc_code = code; exc_pc_next = pcn; exc_bad_addr = bad;
    push_sig(K_VAL, 32'd1, "R8 valid on entry");
    push_sig(K_PC, 32'h8000_0080, "R8 vector on entry");
    tick();
    exc_take = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : driver
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; exc_take = 1'b0; exc_code = '0; exc_pc_next = '0;
    exc_bad_addr = '0; eret = 1'b0; sw_we = 1'b0; sw_addr = '0;
    sw_wdata = '0; hw_irq = '0; rd_addr = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    push_sig(K_IRQ, 32'd0, "R1 irq after reset");
    push_sig(K_VAL, 32'd0, "R1 redirect idle");
    check_reg(5'd12, 32'h0, "R1 status reset");
    check_reg(5'd13, 32'h0, "R1 cause reset");
    check_reg(5'd14, 32'h0, "R1 epc reset");
    check_reg(5'd8,  32'h0, "R1 badvaddr reset");

    // R3 status write, R2 undefined bits
    sw_write(5'd12, 32'hFFFF_FFFF);
    check_reg(5'd12, 32'h0000_FF3F, "R3 status write");
    check_reg(5'd0,  32'h0, "R2 unmapped 0");
    check_reg(5'd31, 32'h0, "R2 unmapped 31");

    // R9 hardware pending, R11 request
    hw_irq = 6'b000001;
    tick();
    push_sig(K_IRQ, 32'd1, "R11 irq enabled unmasked");
    check_reg(5'd13, 32'h0000_0400, "R9 pending latched");
    sw_write(5'd12, 32'h0000_FB3F);
    push_sig(K_IRQ, 32'd0, "R11 irq masked");
    check_reg(5'd13, 32'h0000_0400, "R9 pending held while masked");
    sw_write(5'd12, 32'h0000_FF3E);
    push_sig(K_IRQ, 32'd0, "R11 irq disabled");
    tick();

    // R9 clear by cause write, reload, drop
    sw_write(5'd13, 32'h0);
    check_reg(5'd13, 32'h0, "R9 cleared by write");
    check_reg(5'd13, 32'h0000_0400, "R9 reloaded from line");
    hw_irq = 6'b000000;
    tick();
    check_reg(5'd13, 32'h0, "R9 cleared on line drop");

    // R10 software pending
    sw_write(5'd12, 32'h0000_FF3F);
    sw_write(5'd13, 32'h0000_0300);
    push_sig(K_IRQ, 32'd1, "R10 soft pending raises irq");
    check_reg(5'd13, 32'h0000_0300, "R10 soft pending stored");

    // R4 R5 R6 R7 entry with address error
    sw_write(5'd12, 32'h0000_FF0D);
    take_exc(4'd4, 32'h1000_0104, 32'hDEAD_BEE0);
    check_reg(5'd12, 32'h0000_FF34, "R4 stack push");
    check_reg(5'd13, 32'h0000_0310, "R5 code 4");
    check_reg(5'd14, 32'h1000_0100, "R6 epc capture");
    check_reg(5'd8,  32'hDEAD_BEE0, "R7 badvaddr captured");
    push_sig(K_IRQ, 32'd0, "R4 entry disables irq");
    tick();

    // R7 non address error keeps badvaddr
    take_exc(4'd12, 32'h2000_0008, 32'h1234_5678);
    check_reg(5'd12, 32'h0000_FF10, "R4 second push");
    check_reg(5'd13, 32'h0000_0330, "R5 code 12");
    check_reg(5'd14, 32'h2000_0004, "R6 epc second");
    check_reg(5'd8,  32'hDEAD_BEE0, "R7 badvaddr held");

    // R12 return, R8 redirect to epc
    eret = 1'b1;
    push_sig(K_VAL, 32'd1, "R8 valid on return");
    push_sig(K_PC, 32'h2000_0004, "R8 epc on return");
    tick();
    eret = 1'b0;
    check_reg(5'd12, 32'h0000_FF14, "R12 stack pop");

    // R13 priority and discarded write
    eret = 1'b1; sw_we = 1'b1; sw_addr = 5'd12; sw_wdata = 32'hFFFF_FFFF;
    take_exc(4'd8, 32'h3000_0010, 32'h0);
    eret = 1'b0; sw_we = 1'b0;
    check_reg(5'd12, 32'h0000_FF10, "R13 entry wins over return and write");
    check_reg(5'd13, 32'h0000_0320, "R13 code 8 recorded");
    check_reg(5'd14, 32'h3000_000C, "R13 epc from entry");
    eret = 1'b1; sw_we = 1'b1; sw_addr = 5'd14; sw_wdata = 32'h5555_0000;
    tick();
    eret = 1'b0; sw_we = 1'b0;
    check_reg(5'd14, 32'h3000_000C, "R13 write during return discarded");

    // R6 software write to epc
    sw_write(5'd14, 32'hABCD_0000);
    check_reg(5'd14, 32'hABCD_0000, "R6 epc software write");
    push_sig(K_VAL, 32'd0, "R8 idle after");
    push_sig(K_PC, 32'd0, "R8 idle pc zero");
    tick();

    tick();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule